// File: doc/BRIEF.md
# Instruction-Indexed Stride Prefetcher

This block watches a stream of demand accesses. Each access carries the address of the instruction that made it and the cache-block address it touched. A small, fully associative table keeps one entry per instruction address. Each entry records the last block address it saw and the signed step between successive accesses. Once the same step has repeated often enough, the entry is trusted. Each later access from that instruction then produces a short burst of prefetch block addresses ahead of the demand stream.

Each entry also keeps a prefetch pointer: the last address it has already requested. Two limits bound how far a burst may reach. A lookahead window, set by the prefetch distance, limits it in address space. The prefetch degree limits how many addresses one access may produce. Because of the pointer, steady streams only ask for the addresses that are new. A burst is emitted one address per cycle on a valid/ready output. A refused address is dropped rather than retried. New accesses are held off while a burst is still being emitted.

Top module: `stride_pf`

## Requirements
- R1: An access whose instruction address is not in the table allocates an entry: stored address = access address, step 0, untrained, training count 0. Such an access produces no prefetch.
- R2: On a hit, the observed step is the access address minus the stored address. When it differs from the stored step, the entry takes the new step and its trained flag and training count are cleared.
- R3: On every hit the stored address becomes the access address. While the entry is untrained, each hit adds one to the training count and sets the prefetch pointer to the access address. The entry becomes trained in the hit where the count reaches `cfg_train_thr`; a threshold of 0 trains on the first hit.
- R4: An entry whose step is zero never produces prefetches, trained or not.
- R5: For a trained entry with a nonzero step S, the number of prefetches is min(`cfg_degree`, Q). Q = trunc(((A + (`cfg_dist`+1)·S) − P) / S), taken as 0 when negative. Here A is the access address and P is the prefetch pointer after the R3 update.
- R6: The k-th prefetch of a burst is P + k·S, for k = 1 to the count. They are emitted one per cycle, starting the cycle after the access is taken. The entry's pointer then holds the last address of the burst and carries over to later accesses.
- R7: `pf_ready` low does not stall or repeat a burst. The refused address is dropped and the next cycle presents the following address.
- R8: `acc_ready` is low exactly while a burst has addresses left to emit. An access presented then is not taken until `acc_ready` returns high.
- R9: The table holds ENTRIES entries. An allocation uses the lowest-numbered empty entry, or else the least recently used one. Both allocation and hits count as use.
- R10: Steps are signed, so descending streams prefetch downward. All address arithmetic wraps modulo 2^ADDR_W, and steps are read as ADDR_W-bit two's complement.
- R11: After reset the table is empty, `pf_valid` is 0 and `acc_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Demand access present |
| acc_ready | output | 1 | Access taken this cycle when high (no burst pending) |
| acc_pc | input | PC_W | Instruction address of the access |
| acc_addr | input | ADDR_W | Block address of the access |
| cfg_train_thr | input | CNT_W | Matching steps needed before an entry is trusted |
| cfg_dist | input | DIST_W | Lookahead distance in steps |
| cfg_degree | input | DEG_W | Maximum prefetches per access |
| pf_valid | output | 1 | Prefetch address present |
| pf_ready | input | 1 | Downstream takes the prefetch; refusal drops it |
| pf_addr | output | ADDR_W | Prefetch block address |

## Verification
The bench drives the main function with several access patterns: a short ascending stream, a zero-step repeated address, a stream whose step changes part-way, and a descending stream that crosses address zero. These separate correct training from premature training, show that the zero-step filter works, and expose wrong signed arithmetic or wrong wrap behaviour. Some configurations make the degree the binding limit and others the distance. This shows whether the pointer carry-over and the burst count follow the formula rather than a fixed burst length. Eviction patterns show that a trained stream whose entry was replaced starts over, while a recently touched entry survives. Back-to-back accesses and refused prefetches check the stall and the drop behaviour.

// File: rtl/spf_pkg.sv
// Shared types for the stride prefetcher.
// Assumes nothing beyond IEEE 1800-2017.
package spf_pkg;

    // How an accepted access is treated by its table entry
    typedef enum logic [1:0] {
        UPD_ALLOC   = 2'd0,  // instruction address not present: new entry
        UPD_RETRAIN = 2'd1,  // present, step changed: training restarts
        UPD_LEARN   = 2'd2,  // present, same step, still untrained
        UPD_FOLLOW  = 2'd3   // present, same step, already trained
    } upd_kind_e;

endpackage

// File: rtl/spf_lru.sv
// Recency tracker for a fully associative table.
// Keeps a permutation of ages (0 = most recent).
// Picks the lowest empty slot, else the oldest slot.
// Assumes touch_idx < N whenever touch is high.
module spf_lru #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  slot_vld,
    output logic [IW-1:0] victim_idx
);
    logic [IW-1:0] age [N];

    // age update: touched slot becomes youngest, younger ones age by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    age[i] <= '0;
                else if (age[i] < age[touch_idx])
                    age[i] <= age[i] + 1'b1;
            end
        end
    end

    // victim choice: first empty slot, otherwise the oldest one
    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!slot_vld[i] && !found) begin
                victim_idx = IW'(i);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < N; i++)
                if (age[i] == IW'(N - 1)) victim_idx = IW'(i);
        end
    end
endmodule

// File: rtl/spf_update.sv
// Next-state logic for one table entry on an accepted access.
// Also sizes the prefetch burst from the lookahead window and the degree.
// Purely combinational. Assumes the st_* inputs belong to the hit entry when hit is 1.
module spf_update import spf_pkg::*; #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 4,
    parameter int DIST_W = 4,
    parameter int DEG_W  = 3
) (
    input  logic                     hit,
    input  logic [ADDR_W-1:0]        cur_addr,
    input  logic [ADDR_W-1:0]        st_addr,
    input  logic signed [ADDR_W-1:0] st_stride,
    input  logic                     st_trn,
    input  logic [CNT_W-1:0]         st_cnt,
    input  logic [ADDR_W-1:0]        st_ptr,
    input  logic [CNT_W-1:0]         cfg_thr,
    input  logic [DIST_W-1:0]        cfg_dist,
    input  logic [DEG_W-1:0]         cfg_deg,
    output upd_kind_e                kind,
    output logic [ADDR_W-1:0]        nw_addr,
    output logic signed [ADDR_W-1:0] nw_stride,
    output logic                     nw_trn,
    output logic [CNT_W-1:0]         nw_cnt,
    output logic [ADDR_W-1:0]        nw_ptr,
    output logic [ADDR_W-1:0]        burst_base,
    output logic [DEG_W-1:0]         burst_cnt
);
    localparam int DW      = ADDR_W + DIST_W + 2;
    localparam int PW      = DW + DEG_W;
    localparam int DEG_MAX = (1 << DEG_W) - 1;

    logic signed [ADDR_W-1:0] obs_stride;
    logic                     trn0;
    logic [CNT_W-1:0]         cnt0;
    logic [ADDR_W-1:0]        ptr1;
    logic signed [DW-1:0]     s_ext, gap_ext, win;
    logic [DW-1:0]            abs_s, abs_w;
    logic                     agree;
    logic signed [ADDR_W+DEG_W:0] adv;

    assign obs_stride = $signed(cur_addr - st_addr);

    // classify the access against the stored entry
    always_comb begin
        if (!hit)                      kind = UPD_ALLOC;
        else if (obs_stride != st_stride) kind = UPD_RETRAIN;
        else if (!st_trn)              kind = UPD_LEARN;
        else                           kind = UPD_FOLLOW;
    end

    // training state after the access
    always_comb begin
        nw_addr = cur_addr;
        case (kind)
            UPD_ALLOC:   begin trn0 = 1'b0;   cnt0 = '0;     nw_stride = '0;         end
            UPD_RETRAIN: begin trn0 = 1'b0;   cnt0 = '0;     nw_stride = obs_stride; end
            default:     begin trn0 = st_trn; cnt0 = st_cnt; nw_stride = st_stride;  end
        endcase
        if (kind == UPD_ALLOC) begin
            nw_cnt = '0;
            nw_trn = 1'b0;
            ptr1   = cur_addr;
        end else begin
            nw_cnt = trn0 ? cnt0 : cnt0 + 1'b1;
            ptr1   = trn0 ? st_ptr : cur_addr;
            nw_trn = trn0 | (nw_cnt >= cfg_thr);
        end
    end

    // lookahead window: limit minus pointer, in wide signed arithmetic
    always_comb begin
        s_ext   = {{(DW-ADDR_W){nw_stride[ADDR_W-1]}}, nw_stride};
        gap_ext = {{(DW-ADDR_W){1'b0}}, cur_addr - ptr1};
        gap_ext = {{(DW-ADDR_W){gap_ext[ADDR_W-1]}}, gap_ext[ADDR_W-1:0]};
        win     = gap_ext + s_ext * $signed(DW'({1'b0, cfg_dist}) + DW'(1));
        abs_s   = s_ext[DW-1] ? DW'(-s_ext) : DW'(s_ext);
        abs_w   = win[DW-1]   ? DW'(-win)   : DW'(win);
        agree   = (win != '0) && (win[DW-1] == s_ext[DW-1]);
    end

    // burst size: how many whole steps fit in the window, capped at the degree
    always_comb begin
        burst_cnt = '0;
        if (nw_trn && (nw_stride != '0) && agree) begin
            for (int k = 1; k <= DEG_MAX; k++) begin
                if ((DEG_W'(k) <= cfg_deg) &&
                    (PW'(k) * PW'(abs_s) <= PW'(abs_w)))
                    burst_cnt = burst_cnt + 1'b1;
            end
        end
    end

    // pointer after the burst: base plus count steps
    always_comb begin
        adv        = $signed({1'b0, burst_cnt}) * nw_stride;
        burst_base = ptr1;
        nw_ptr     = ptr1 + adv[ADDR_W-1:0];
    end
endmodule

// File: rtl/spf_burst.sv
// Emits a loaded burst of prefetch addresses, one per cycle.
// A refused address is dropped unless HOLD_ON_REFUSE is set.
// Assumes load only arrives while busy is low.
module spf_burst #(
    parameter int ADDR_W         = 24,
    parameter int DEG_W          = 3,
    parameter bit HOLD_ON_REFUSE = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [ADDR_W-1:0]        ld_base,
    input  logic signed [ADDR_W-1:0] ld_step,
    input  logic [DEG_W-1:0]         ld_cnt,
    input  logic                     pf_ready,
    output logic                     pf_valid,
    output logic [ADDR_W-1:0]        pf_addr,
    output logic                     busy
);
    logic [DEG_W-1:0]         left;
    logic [ADDR_W-1:0]        nxt;
    logic signed [ADDR_W-1:0] step;
    logic                     adv;

    assign pf_valid = (left != '0);
    assign busy     = pf_valid;
    assign pf_addr  = nxt;
    assign adv      = pf_valid && (pf_ready || !HOLD_ON_REFUSE);

    // burst state: load a new burst or step through the current one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
            nxt  <= '0;
            step <= '0;
        end else if (load) begin
            left <= ld_cnt;
            nxt  <= ld_base + ld_step;
            step <= ld_step;
        end else if (adv) begin
            left <= left - 1'b1;
            nxt  <= nxt + step;
        end
    end
endmodule

// File: rtl/stride_pf.sv
// Instruction-indexed stride prefetcher, top level.
// A fully associative table of ENTRIES entries learns one step per instruction address.
// Trained entries send prefetch bursts through spf_burst.
// Assumes cfg_* are stable while a burst is being emitted.
module stride_pf import spf_pkg::*; #(
    parameter int PC_W    = 16,
    parameter int ADDR_W  = 24,
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 4,
    parameter int DIST_W  = 4,
    parameter int DEG_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic [PC_W-1:0]   acc_pc,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [CNT_W-1:0]  cfg_train_thr,
    input  logic [DIST_W-1:0] cfg_dist,
    input  logic [DEG_W-1:0]  cfg_degree,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]       e_vld, e_trn, hit_vec;
    logic [PC_W-1:0]          e_pc   [ENTRIES];
    logic [ADDR_W-1:0]        e_addr [ENTRIES];
    logic [ADDR_W-1:0]        e_ptr  [ENTRIES];
    logic signed [ADDR_W-1:0] e_str  [ENTRIES];
    logic [CNT_W-1:0]         e_cnt  [ENTRIES];

    logic          lk_hit, acc_fire, busy;
    logic [IW-1:0] hit_idx, vic_idx, sel_idx;

    upd_kind_e                kind;
    logic [ADDR_W-1:0]        nw_addr, nw_ptr, burst_base;
    logic signed [ADDR_W-1:0] nw_stride;
    logic                     nw_trn;
    logic [CNT_W-1:0]         nw_cnt;
    logic [DEG_W-1:0]         burst_cnt;

    // one comparator per entry
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cam
            assign hit_vec[g] = e_vld[g] && (e_pc[g] == acc_pc);
        end
    endgenerate

    assign lk_hit    = |hit_vec;
    assign acc_ready = !busy;
    assign acc_fire  = acc_valid && acc_ready;
    assign sel_idx   = lk_hit ? hit_idx : vic_idx;

    // encode the matching entry
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (hit_vec[i]) hit_idx = IW'(i);
    end

    spf_lru #(.N(ENTRIES), .IW(IW)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (acc_fire),
        .touch_idx  (sel_idx),
        .slot_vld   (e_vld),
        .victim_idx (vic_idx)
    );

    spf_update #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIST_W(DIST_W), .DEG_W(DEG_W)) u_upd (
        .hit        (lk_hit),
        .cur_addr   (acc_addr),
        .st_addr    (e_addr[sel_idx]),
        .st_stride  (e_str[sel_idx]),
        .st_trn     (e_trn[sel_idx]),
        .st_cnt     (e_cnt[sel_idx]),
        .st_ptr     (e_ptr[sel_idx]),
        .cfg_thr    (cfg_train_thr),
        .cfg_dist   (cfg_dist),
        .cfg_deg    (cfg_degree),
        .kind       (kind),
        .nw_addr    (nw_addr),
        .nw_stride  (nw_stride),
        .nw_trn     (nw_trn),
        .nw_cnt     (nw_cnt),
        .nw_ptr     (nw_ptr),
        .burst_base (burst_base),
        .burst_cnt  (burst_cnt)
    );

    // table write: the selected entry takes its new state on an accepted access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_vld <= '0;
            e_trn <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                e_pc[i]   <= '0;
                e_addr[i] <= '0;
                e_ptr[i]  <= '0;
                e_str[i]  <= '0;
                e_cnt[i]  <= '0;
            end
        end else if (acc_fire) begin
            e_vld[sel_idx]  <= 1'b1;
            e_trn[sel_idx]  <= nw_trn;
            e_pc[sel_idx]   <= acc_pc;
            e_addr[sel_idx] <= nw_addr;
            e_ptr[sel_idx]  <= nw_ptr;
            e_str[sel_idx]  <= nw_stride;
            e_cnt[sel_idx]  <= nw_cnt;
        end
    end

    spf_burst #(.ADDR_W(ADDR_W), .DEG_W(DEG_W), .HOLD_ON_REFUSE(1'b0)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc_fire && (kind != UPD_ALLOC)),
        .ld_base  (burst_base),
        .ld_step  (nw_stride),
        .ld_cnt   (burst_cnt),
        .pf_ready (pf_ready),
        .pf_valid (pf_valid),
        .pf_addr  (pf_addr),
        .busy     (busy)
    );
endmodule

// File: rtl/spf_chk.sv
// Protocol and burst-shape checks for stride_pf, attached with bind.
// Assumes cfg_degree is stable while a burst is being emitted.
module spf_chk #(
    parameter int ADDR_W = 24,
    parameter int DEG_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic              lk_hit,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic [DEG_W-1:0]  cfg_degree
);
    logic [DEG_W:0] run;

    // length of the current run of prefetch cycles
    always_ff @(posedge clk) begin
        if (!rst_n)        run <= '0;
        else if (pf_valid) run <= run + 1'b1;
        else               run <= '0;
    end

    // R5
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (run < {1'b0, cfg_degree}));

    // R6
    even_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && $past(pf_valid) && $past(pf_valid, 2)) |->
        ((pf_addr - $past(pf_addr)) == ($past(pf_addr) - $past(pf_addr, 2))));

    // R6
    burst_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> $past(acc_valid && acc_ready));

    // R1
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && !lk_hit) |=> !pf_valid);

    // R8
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !acc_ready);

    // R7
    drop_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pf_valid && !pf_ready) && pf_valid) |-> (pf_addr != $past(pf_addr)));
endmodule

bind stride_pf spf_chk #(.ADDR_W(ADDR_W), .DEG_W(DEG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_ready  (acc_ready),
    .lk_hit     (lk_hit),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr),
    .cfg_degree (cfg_degree)
);

// File: tb/tb_stride_pf.sv
// Bench for stride_pf: a behavioural reference model is stepped each clock
// and compared with the outputs at every falling edge.
module tb_stride_pf;
    localparam int PC_W = 16, ADDR_W = 24, ENTRIES = 4, CNT_W = 4, DIST_W = 4, DEG_W = 3;
    localparam longint MASK = (longint'(1) << ADDR_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_ready, pf_valid, pf_ready = 1'b1;
    logic [PC_W-1:0]   acc_pc = '0;
    logic [ADDR_W-1:0] acc_addr = '0, pf_addr;
    logic [CNT_W-1:0]  cfg_train_thr = 4'd2;
    logic [DIST_W-1:0] cfg_dist = 4'd3;
    logic [DEG_W-1:0]  cfg_degree = 3'd2;

    always #5 clk = ~clk;

    stride_pf #(.PC_W(PC_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W),
                .DIST_W(DIST_W), .DEG_W(DEG_W)) dut (.*);

    int checks = 0, errors = 0, cyc = 0, rdy_mode = 0;
    bit done = 1'b0, fired;
    string tag = "R11";

    // reference model state
    bit     m_vld [ENTRIES];
    bit     m_trn [ENTRIES];
    longint m_pc [ENTRIES], m_addr [ENTRIES], m_str [ENTRIES], m_ptr [ENTRIES], m_use [ENTRIES];
    int     m_cnt [ENTRIES];
    longint stamp = 0, b_addr = 0, b_step = 0;
    int     b_left = 0;

    function automatic longint sx(longint v);
        longint w = v & MASK;
        if (w[ADDR_W-1]) w = w - (longint'(1) << ADDR_W);
        return w;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // model of one clock edge with the inputs now being driven
    task automatic model_step(bit av, longint pc, longint a);
        int idx = -1;
        fired = 1'b0;
        if (b_left > 0) begin
            b_addr = (b_addr + b_step) & MASK;
            b_left--;
        end else if (av) begin
            fired = 1'b1;
            stamp++;
            for (int i = 0; i < ENTRIES; i++)
                if (m_vld[i] && m_pc[i] == pc) idx = i;
            if (idx < 0) begin
                for (int i = ENTRIES - 1; i >= 0; i--) if (!m_vld[i]) idx = i;
                if (idx < 0) begin
                    idx = 0;
                    for (int i = 1; i < ENTRIES; i++) if (m_use[i] < m_use[idx]) idx = i;
                end
                m_vld[idx] = 1; m_pc[idx] = pc; m_addr[idx] = a; m_str[idx] = 0;
                m_trn[idx] = 0; m_cnt[idx] = 0; m_ptr[idx] = a; m_use[idx] = stamp;
            end else begin
                longint ns = sx(a - m_addr[idx]);
                longint q = 0;
                if (ns != m_str[idx]) begin
                    m_str[idx] = ns; m_trn[idx] = 0; m_cnt[idx] = 0;
                end
                m_addr[idx] = a;
                if (!m_trn[idx]) begin m_cnt[idx]++; m_ptr[idx] = a; end
                if (m_cnt[idx] >= int'(cfg_train_thr)) m_trn[idx] = 1;
                m_use[idx] = stamp;
                if (m_str[idx] != 0 && m_trn[idx]) begin
                    longint d = sx(a - m_ptr[idx]) + (longint'(cfg_dist) + 1) * m_str[idx];
                    q = d / m_str[idx];
                    if (q < 0) q = 0;
                    if (q > longint'(cfg_degree)) q = longint'(cfg_degree);
                end
                b_left = int'(q);
                b_addr = (m_ptr[idx] + m_str[idx]) & MASK;
                b_step = m_str[idx];
                m_ptr[idx] = (m_ptr[idx] + q * m_str[idx]) & MASK;
            end
        end
    endtask

    // drive one cycle (called at a falling edge), then compare at the next falling edge
    task automatic tick(bit av, longint pc, longint a);
        acc_valid = av;
        acc_pc    = PC_W'(pc);
        acc_addr  = ADDR_W'(a & MASK);
        pf_ready  = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : cyc[0];
        model_step(av, pc, a & MASK);
        @(negedge clk);
        cyc++;
        check(tag, "acc_ready (R8)", longint'(acc_ready), longint'(b_left == 0));
        check(tag, "pf_valid", longint'(pf_valid), longint'(b_left != 0));
        if (b_left != 0) check(tag, "pf_addr", longint'(pf_addr), b_addr);
    endtask

    task automatic acc_hold(longint pc, longint a);
        fired = 1'b0;
        while (!fired) tick(1'b1, pc, a);
        acc_valid = 1'b0;
    endtask

    task automatic acc(longint pc, longint a);
        acc_hold(pc, a);
        while (b_left > 0) tick(1'b0, 0, 0);
        tick(1'b0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            m_vld[i] = 0; m_trn[i] = 0; m_pc[i] = 0; m_addr[i] = 0;
            m_str[i] = 0; m_ptr[i] = 0; m_use[i] = 0; m_cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        check("R11", "acc_ready after reset", longint'(acc_ready), 1);
        check("R11", "pf_valid after reset", longint'(pf_valid), 0);

        tag = "R1";  acc(16'h10, 100);
        tag = "R3";  acc(16'h10, 104); acc(16'h10, 108);
        tag = "R6";  acc(16'h10, 112); acc(16'h10, 116);
        tag = "R4";  acc(16'h20, 500); acc(16'h20, 500); acc(16'h20, 500); acc(16'h20, 500);
        tag = "R2";  acc(16'h10, 130); acc(16'h10, 148); acc(16'h10, 166);
        tag = "R5";  cfg_degree = 3'd7; cfg_dist = 4'd1;
        for (int k = 0; k < 5; k++) acc(16'h40, 1000 + 10 * k);
        tag = "R10"; cfg_degree = 3'd3; cfg_dist = 4'd2;
        for (int k = 0; k < 5; k++) acc(16'h30, 16 - 8 * k);
        tag = "R7";  rdy_mode = 2; acc(16'h30, -24); acc(16'h30, -32);
        rdy_mode = 1; acc(16'h30, -40); acc(16'h30, -48); rdy_mode = 0;
        tag = "R8";  acc_hold(16'h10, 184); acc_hold(16'h10, 202);
        while (b_left > 0) tick(1'b0, 0, 0);
        tick(1'b0, 0, 0);
        tag = "R9";  acc(16'h50, 16'h2000); acc(16'h20, 500); acc(16'h40, 1050);
        acc(16'h40, 1060); acc(16'h10, 220);
        tag = "R3";  cfg_train_thr = 4'd0; acc(16'h60, 16'h3000); acc(16'h60, 16'h3004);
        acc(16'h60, 16'h3008);
        cfg_train_thr = 4'd2;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog %s actual=hung expected=finished", tag);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule